// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block sits between a clocked on-chip read bus and an external asynchronous mask ROM. The ROM can read in page mode and can be switched between 16-bit word and 8-bit byte organisation. Each bus request carries a 20-bit byte address and a flag that selects byte or word width. The controller drives the ROM's chip-select, output-enable, width-select and address pins, waits a set number of clock cycles, and then returns the captured data as a one-cycle response pulse.

The controller keeps the current ROM page open between requests, with chip select and output enable held active. A page is one group of 8 bytes, or 4 words. A request that falls in the open page changes only the low address lines and waits the short in-page time. A request to another page waits the full random-access time. A request that arrives while the ROM is closed also waits long enough to cover the output-enable delay. The page is closed in two cases: when the bus stays quiet for a set number of cycles, or when a request asks for the other width. After a close, no new access starts until the data lines have had time to float. All timings are clock-cycle parameters.

Top module: `prom_rd_ctrl`

## Requirements
- R1: Out of reset `rom_ce_n` and `rom_oe_n` are high, `rsp_valid` is low and `req_ready` is high. `req_ready` is low while an access is in progress.
- R2: An accepted request drives `rom_addr` = `req_addr[19:1]` and `rom_word` = not `req_byte` (1 = word). In byte mode `rom_lsb_en` is 1 and `rom_lsb` = `req_addr[0]`. In word mode `rom_lsb_en` is 0.
- R3: A request whose page (`req_addr[19:3]`) and width match the open page gives `rsp_valid` exactly PAGE_CYC+1 cycles after the accepting edge.
- R4: A request to a different page of the same width, with a page open, gives `rsp_valid` RAND_CYC+1 cycles after the accepting edge.
- R5: A request accepted while the ROM is closed gives `rsp_valid` max(RAND_CYC, OE_CYC)+1 cycles after the accepting edge.
- R6: From acceptance until the response, `rom_ce_n` and `rom_oe_n` are low and the address, `rom_lsb` and `rom_word` pins do not change.
- R7: In word mode `rsp_data` equals the ROM data lines. In byte mode `rsp_data` is {8'h00, data[7:0]}.
- R8: After IDLE_CYC consecutive cycles with a page open and no request, `rom_ce_n` and `rom_oe_n` go high. The next access is then a closed-ROM access.
- R9: A request of the other width while a page is open first raises `rom_ce_n`/`rom_oe_n`. These stay high for at least DF_CYC cycles before the request is accepted, and the request is then a closed-ROM access.
- R10: Each accepted request produces exactly one `rsp_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | ADDR_W | Byte address |
| req_byte | input | 1 | 1 = byte-wide read, 0 = word read |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 16 | Read data, upper byte zero in byte mode |
| rom_ce_n | output | 1 | ROM chip select, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM width select, 1 = word |
| rom_addr | output | ADDR_W-1 | ROM address lines A0 upward |
| rom_lsb | output | 1 | Byte-select address driven onto the top data pin |
| rom_lsb_en | output | 1 | Drive enable for `rom_lsb` (byte mode) |
| rom_dq | input | 16 | ROM data lines |

## Verification
The idle timeout and the timed close are the hardest conditions to reach from the ports. A request must land inside or outside the quiet window, and a width switch must arrive while a page is still open. The random stimulus therefore places each request after either a short gap, kept well below IDLE_CYC, or a long gap that exceeds the timeout plus the float time. It also mixes same-page, other-page and width-switching addresses. This makes the expected latency class of every request known in advance. Directed cases cover each class once, and they measure how long chip select stays high across a width switch.

// File: rtl/prom_pkg.sv
package prom_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    ST_CLOSED,
    ST_OPEN,
    ST_WAIT,
    ST_CAPT,
    ST_FLOAT
  } prom_st_e;

  typedef enum logic [1:0] {
    ACC_HIT,
    ACC_MISS,
    ACC_COLD
  } acc_kind_e;

  // wait for an access started from a closed ROM
  function automatic int cold_wait(input int rand_cyc, input int oe_cyc);
    return (rand_cyc > oe_cyc) ? rand_cyc : oe_cyc;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // response formatting: byte reads zero the upper half
  function automatic logic [DATA_W-1:0] fmt_rsp(input logic [DATA_W-1:0] dq,
                                                input logic byte_m);
    return byte_m ? {8'h00, dq[7:0]} : dq;
  endfunction

endpackage

// File: rtl/prom_page_trk.sv
module prom_page_trk #(
  parameter int TAG_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clr,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             load_byte,
  input  logic [TAG_W-1:0] q_tag,
  input  logic             q_byte,
  output logic             pg_vld,
  output logic             same_mode,
  output logic             hit
);
  logic [TAG_W-1:0] tag_r;
  logic             byte_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_vld <= 1'b0;
      tag_r  <= '0;
      byte_r <= 1'b0;
    end else if (clr) begin
      pg_vld <= 1'b0;
    end else if (load) begin
      pg_vld <= 1'b1;
      tag_r  <= load_tag;
      byte_r <= load_byte;
    end
  end

  assign same_mode = pg_vld && (byte_r == q_byte);
  assign hit       = same_mode && (tag_r == q_tag);
endmodule

// File: rtl/prom_cdown.sv
module prom_cdown #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/prom_idle_tmr.sv
module prom_idle_tmr #(
  parameter int IDLE_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  logic [IW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expire)   cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == IW'(IDLE_CYC - 1));
endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
  import prom_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int RAND_CYC = 13,
  parameter int PAGE_CYC = 4,
  parameter int OE_CYC   = 4,
  parameter int DF_CYC   = 3,
  parameter int IDLE_CYC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_byte,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_word,
  output logic [ADDR_W-2:0] rom_addr,
  output logic              rom_lsb,
  output logic              rom_lsb_en,
  input  logic [15:0]       rom_dq
);
  localparam int TAG_W    = ADDR_W - 3;
  localparam int COLD_CYC = cold_wait(RAND_CYC, OE_CYC);
  localparam int MAX_CYC  = max3(COLD_CYC, PAGE_CYC, DF_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  prom_st_e state;

  // named internal events
  logic             pg_vld, trk_same, trk_hit;
  logic             acc_fire, acc_hit, acc_miss, acc_cold;
  logic             close_now, idle_exp, tmr_last, in_wait, idle_run;
  logic [CNT_W-1:0] wait_len, tmr_val;

  prom_page_trk #(.TAG_W(TAG_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc_fire),
    .clr       (close_now),
    .load_tag  (req_addr[ADDR_W-1:3]),
    .load_byte (req_byte),
    .q_tag     (req_addr[ADDR_W-1:3]),
    .q_byte    (req_byte),
    .pg_vld    (pg_vld),
    .same_mode (trk_same),
    .hit       (trk_hit)
  );

  prom_cdown #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc_fire || close_now),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  prom_idle_tmr #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (idle_run),
    .expire (idle_exp)
  );

  assign req_ready = (state == ST_CLOSED) || ((state == ST_OPEN) && trk_same);
  assign acc_fire  = req_valid && req_ready;
  assign acc_hit   = acc_fire && (state == ST_OPEN) && trk_hit;
  assign acc_miss  = acc_fire && (state == ST_OPEN) && !trk_hit;
  assign acc_cold  = acc_fire && (state == ST_CLOSED);
  assign idle_run  = (state == ST_OPEN) && !req_valid;
  assign close_now = (state == ST_OPEN) && pg_vld &&
                     ((req_valid && !trk_same) || idle_exp);
  assign in_wait   = (state == ST_WAIT) || (state == ST_CAPT);

  always_comb begin
    if (acc_hit)       wait_len = CNT_W'(PAGE_CYC);
    else if (acc_miss) wait_len = CNT_W'(RAND_CYC);
    else               wait_len = CNT_W'(COLD_CYC);
    tmr_val = acc_fire ? wait_len : CNT_W'(DF_CYC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_CLOSED;
      rom_ce_n   <= 1'b1;
      rom_oe_n   <= 1'b1;
      rom_word   <= 1'b1;
      rom_addr   <= '0;
      rom_lsb    <= 1'b0;
      rom_lsb_en <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_CLOSED, ST_OPEN: begin
          if (acc_fire) begin
            rom_ce_n   <= 1'b0;
            rom_oe_n   <= 1'b0;
            rom_word   <= !req_byte;
            rom_addr   <= req_addr[ADDR_W-1:1];
            rom_lsb    <= req_byte & req_addr[0];
            rom_lsb_en <= req_byte;
            state      <= ST_WAIT;
          end else if (close_now) begin
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
            state    <= ST_FLOAT;
          end
        end
        ST_WAIT: if (tmr_last) state <= ST_CAPT;
        ST_CAPT: begin
          rsp_valid <= 1'b1;
          rsp_data  <= fmt_rsp(rom_dq, rom_lsb_en);
          state     <= ST_OPEN;
        end
        ST_FLOAT: if (tmr_last) state <= ST_CLOSED;
        default: state <= ST_CLOSED;
      endcase
    end
  end
endmodule

// File: rtl/prom_rd_ctrl_chk.sv
module prom_rd_ctrl_chk
  import prom_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int RAND_CYC = 13,
  parameter int PAGE_CYC = 4,
  parameter int OE_CYC   = 4,
  parameter int DF_CYC   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [15:0]       rsp_data,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              rom_word,
  input logic [ADDR_W-2:0] rom_addr,
  input logic              rom_lsb,
  input logic              rom_lsb_en,
  input logic              in_wait,
  input logic              acc_hit,
  input logic              acc_miss,
  input logic              acc_cold
);
  logic [15:0] lat, hi_cnt;
  acc_kind_e   kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat  <= '0;
      kind <= ACC_COLD;
    end else if (acc_hit || acc_miss || acc_cold) begin
      lat  <= '0;
      kind <= acc_hit ? ACC_HIT : (acc_miss ? ACC_MISS : ACC_COLD);
    end else if (lat != 16'hFFFF) begin
      lat <= lat + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           hi_cnt <= 16'(DF_CYC);
    else if (!rom_ce_n)                   hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF)          hi_cnt <= hi_cnt + 1'b1;
  end

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !req_ready);

  a_r2_lsb_follows_width: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n |-> (rom_lsb_en == !rom_word));

  a_r3_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && kind == ACC_HIT) |-> (lat == 16'(PAGE_CYC + 1)));

  a_r4_miss_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && kind == ACC_MISS) |-> (lat == 16'(RAND_CYC + 1)));

  a_r5_cold_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && kind == ACC_COLD) |-> (lat == 16'(cold_wait(RAND_CYC, OE_CYC) + 1)));

  a_r6_selects_active: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> (!rom_ce_n && !rom_oe_n));

  a_r6_pins_stable: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |=> ($stable(rom_addr) && $stable(rom_lsb) && $stable(rom_word)));

  a_r7_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rom_word) |-> (rsp_data[15:8] == 8'h00));

  a_r9_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rom_ce_n) |-> (hi_cnt >= 16'(DF_CYC)));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .RAND_CYC (RAND_CYC),
  .PAGE_CYC (PAGE_CYC),
  .OE_CYC   (OE_CYC),
  .DF_CYC   (DF_CYC)
) u_chk (.*);

// File: tb/prom_rd_ctrl_tb.sv
module prom_rd_ctrl_tb_top;
  localparam int RAND_CYC = 13;
  localparam int PAGE_CYC = 4;
  localparam int OE_CYC   = 4;
  localparam int DF_CYC   = 3;
  localparam int IDLE_CYC = 32;
  localparam int COLD_LAT = ((RAND_CYC > OE_CYC) ? RAND_CYC : OE_CYC) + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rom_ce_n, rom_oe_n, rom_word, rom_lsb, rom_lsb_en;
  logic [18:0] rom_addr;
  logic [15:0] rom_dq;

  int checks = 0;
  int fails  = 0;
  int hi_run = 0;
  int last_hi_run = 0;

  // model state
  logic        m_open = 1'b0;
  logic [16:0] m_tag  = '0;
  logic        m_byte = 1'b0;

  always #4 clk = ~clk;

  prom_rd_ctrl #(
    .ADDR_W(20), .RAND_CYC(RAND_CYC), .PAGE_CYC(PAGE_CYC),
    .OE_CYC(OE_CYC), .DF_CYC(DF_CYC), .IDLE_CYC(IDLE_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
    .rom_word(rom_word), .rom_addr(rom_addr), .rom_lsb(rom_lsb),
    .rom_lsb_en(rom_lsb_en), .rom_dq(rom_dq)
  );

  function automatic logic [15:0] rom_word_at(input logic [18:0] a);
    logic [31:0] t;
    t = {13'd0, a} * 32'd40503 + 32'h1234;
    return t[23:8];
  endfunction

  function automatic logic [15:0] exp_data(input logic [19:0] a, input logic bm);
    logic [15:0] w;
    w = rom_word_at(a[19:1]);
    if (!bm) return w;
    return {8'h00, a[0] ? w[15:8] : w[7:0]};
  endfunction

  function automatic int exp_lat(input logic [19:0] a, input logic bm);
    if (!m_open || m_byte != bm) return COLD_LAT;
    if (m_tag == a[19:3])        return PAGE_CYC + 1;
    return RAND_CYC + 1;
  endfunction

  // ROM model: upper pins float (junk) in byte mode, top pin is the lsb input
  always_comb begin
    logic [15:0] w;
    w = rom_word_at(rom_addr);
    if (rom_ce_n || rom_oe_n) rom_dq = 16'hDEAD;
    else if (rom_word)        rom_dq = w;
    else                      rom_dq = {rom_lsb, 7'h55, rom_lsb ? w[15:8] : w[7:0]};
  end

  always @(negedge clk) begin
    if (rom_ce_n) hi_run++;
    else begin
      if (hi_run != 0) last_hi_run = hi_run;
      hi_run = 0;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic [19:0] a, input logic bm);
    int lat, elat, guard;
    elat = exp_lat(a, bm);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_byte = bm;
    #1;
    guard = 0;
    while (!req_ready && guard < 500) begin @(negedge clk); #1; guard++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rom_addr == a[19:1], "R2 address", int'(rom_addr), int'(a[19:1]));
    check(rom_word == !bm && rom_lsb_en == bm && (!bm || rom_lsb == a[0]),
          "R2 width/lsb pins", {rom_word, rom_lsb_en, rom_lsb}, {!bm, bm, bm & a[0]});
    check(!rom_ce_n && !rom_oe_n, "R6 selects active", {rom_ce_n, rom_oe_n}, 0);
    lat = 0;
    while (!rsp_valid && lat < 600) begin @(negedge clk); lat++; end
    if (elat == PAGE_CYC + 1)      check(lat == elat, "R3 hit latency", lat, elat);
    else if (elat == RAND_CYC + 1) check(lat == elat, "R4 miss latency", lat, elat);
    else                           check(lat == elat, "R5 closed latency", lat, elat);
    check(rsp_data == exp_data(a, bm), "R7 data", int'(rsp_data), int'(exp_data(a, bm)));
    check(rom_addr == a[19:1] && !rom_ce_n, "R6 pins held", int'(rom_addr), int'(a[19:1]));
    @(negedge clk);
    check(!rsp_valid, "R10 single pulse", rsp_valid, 0);
    m_open = 1'b1; m_tag = a[19:3]; m_byte = bm;
  endtask

  task automatic long_idle();
    repeat (IDLE_CYC + DF_CYC + 6) @(negedge clk);
    check(rom_ce_n && rom_oe_n, "R8 idle close", {rom_ce_n, rom_oe_n}, 3);
    m_open = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    logic [19:0] a;
    logic        bm;
    int          r, closed_before;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(rom_ce_n && rom_oe_n && !rsp_valid && req_ready, "R1 reset state",
          {rom_ce_n, rom_oe_n, rsp_valid, req_ready}, 4'b1101);

    // directed corners
    do_req(20'h00010, 1'b0);          // R5 closed access
    do_req(20'h00014, 1'b0);          // R3 same page
    do_req(20'h00101, 1'b0);          // R4 other page, lsb ignored in word mode
    do_req(20'h00101, 1'b1);          // R9 width switch
    check(last_hi_run >= DF_CYC, "R9 float gap", last_hi_run, DF_CYC);
    do_req(20'h00106, 1'b1);          // R3 byte hit, other byte
    long_idle();                      // R8
    do_req(20'h00106, 1'b1);          // R8 next access is closed-ROM
    do_req(20'hFFFFF, 1'b1);          // top byte
    do_req(20'hFFFFE, 1'b0);          // R9 back to word

    // constrained random
    for (int i = 0; i < 300; i++) begin
      r = $urandom_range(0, 99);
      if (r < 50)      a = {m_tag, 3'($urandom_range(0, 7))};
      else if (r < 75) a = {m_tag + 17'($urandom_range(1, 3)), 3'($urandom_range(0, 7))};
      else             a = 20'($urandom);
      bm = ($urandom_range(0, 99) < 85) ? m_byte : !m_byte;
      if ($urandom_range(0, 7) == 0) long_idle();
      else repeat ($urandom_range(0, IDLE_CYC - 8)) @(negedge clk);
      closed_before = (m_open && m_byte != bm) ? 1 : 0;
      do_req(a, bm);
      if (closed_before != 0)
        check(last_hi_run >= DF_CYC, "R9 float gap", last_hi_run, DF_CYC);
    end
    finish_run();
  end
endmodule